// File: doc/BRIEF.md
# DRAM Strobe Cycle Decoder

This block watches the control strobes of an asynchronous DRAM device: one row strobe, a column strobe per byte lane, write enable and output enable. All of them are active low and sampled on a fast system clock. From these strobes it works out what kind of access the host is making. It produces a registered cycle-mode code, a one-clock write pulse for each lane and each column access, and an output-drive enable for each lane.

The cycle mode is decided by the first column access of a row cycle. Both column strobes are combined for this decision. Writes and output turn-off are then handled separately on each lane. A lane-mismatch flag is raised when, within one row cycle, one lane is written with an early write and the other with a delayed write. The block is meant to be the control core of a DRAM behavioural model or of a bus monitor. It contains no storage array and no analog timing checks.

Every output is registered. Each output reflects the strobes seen at the previous rising clock edge. Lane 0 is the lower byte, bit 0 of `cas_ni`.

Top module: `dram_cycle_decoder`

## Requirements
- R1: After reset, and on every cycle after the row strobe is sampled high, `mode_o` is 0 (idle). When the row strobe and all column strobes are high, every `drive_o` bit is 0.
- R2: A row strobe fall while any column strobe is low sets `mode_o` to 6 (strobe-first refresh). No write pulse occurs anywhere in that row cycle.
- R3: A row strobe fall with all column strobes high sets `mode_o` to 5 (row-only refresh). The code stays 5 until a column strobe falls.
- R4: If the first column strobe falls while write enable is low, `mode_o` becomes 2 (early write). Each lane whose strobe fell gets one write pulse, and no lane drives.
- R5: If the first column strobe falls while write enable is high, `mode_o` becomes 1 (read). A lane drives only while its own column strobe is low and output enable is low. With output enable high, no lane drives.
- R6: A driving lane keeps driving in two cases: while its column strobe is high and the row strobe is still low, and while the row strobe is high and its column strobe is still low. It stops when both are high, when output enable goes high, or when write enable is low.
- R7: In a read row, a write-enable fall with a column strobe low, when output enable was never low during the row, sets `mode_o` to 3 (delayed write). Each lane whose strobe was low on both samples gets one pulse.
- R8: The same write-enable fall, after output enable had been low earlier in the row, sets `mode_o` to 4 (read-modify-write) and pulses the same lanes.
- R9: Later column accesses in the same row (page accesses) leave `mode_o` unchanged. Each of them still produces write pulses under the R4 and R7 lane rules.
- R10: `lane_err_o` rises when, within one row cycle, one lane has recorded an early write and another a delayed write. It stays set until the row strobe is sampled high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Sampling clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| ras_ni | input | 1 | Row strobe, active low |
| cas_ni | input | NUM_LANES | Column strobe per lane, active low, bit 0 lower byte |
| we_ni | input | 1 | Write enable, active low |
| oe_ni | input | 1 | Output enable, active low |
| mode_o | output | 3 | Cycle-mode code |
| wr_stb_o | output | NUM_LANES | One-clock write pulse per lane |
| drive_o | output | NUM_LANES | Output-drive enable per lane |
| lane_err_o | output | 1 | Mixed write kinds across lanes |

## Verification
Two functions can fall in the same clock: a write-enable fall that upgrades the row to a delayed write, and a column-strobe fall on the other lane, which can give that lane an early write in that very sample. The bench provokes this both in one clock and spread over several clocks. It also places a row strobe rise under a column strobe that is still low (hidden refresh), so that the drive hold of R6 overlaps the new refresh classification of R2. A behavioural model rebuilt every clock judges mode, pulses, drives and the error flag together.

// File: rtl/dram_dec_pkg.sv
package dram_dec_pkg;
  typedef enum logic [2:0] {
    MODE_IDLE     = 3'd0,
    MODE_READ     = 3'd1,
    MODE_EARLY_WR = 3'd2,
    MODE_LATE_WR  = 3'd3,
    MODE_RMW      = 3'd4,
    MODE_ROW_REF  = 3'd5,
    MODE_CBR_REF  = 3'd6
  } cyc_mode_e;

  typedef enum logic [1:0] {
    WK_NONE  = 2'd0,
    WK_EARLY = 2'd1,
    WK_LATE  = 2'd2
  } wr_kind_e;
endpackage

// File: rtl/dram_strobe_sampler.sv
module dram_strobe_sampler #(
  parameter int NUM_LANES = 2
) (
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic [NUM_LANES-1:0] cas_ni,
  input  logic                 we_ni,
  output logic [NUM_LANES-1:0] cas_q_o,
  output logic                 we_q_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cas_q_o <= '1;
      we_q_o  <= 1'b1;
    end else begin
      cas_q_o <= cas_ni;
      we_q_o  <= we_ni;
    end
  end
endmodule

// File: rtl/dram_mode_fsm.sv
module dram_mode_fsm
  import dram_dec_pkg::*;
(
  input  logic      clk_i,
  input  logic      rst_ni,
  input  logic      ras_ni,
  input  logic      cas_any_i,
  input  logic      we_ni,
  input  logic      we_q_i,
  input  logic      oe_ni,
  output cyc_mode_e mode_q_o,
  output cyc_mode_e mode_nxt_o,
  output logic      wr_ok_o
);
  cyc_mode_e mode_q, mode_d;
  logic      oe_seen_q, oe_seen_d;
  logic      we_fall;

  assign we_fall = !we_ni && we_q_i;

  always_comb begin
    mode_d = mode_q;
    if (ras_ni) mode_d = MODE_IDLE;
    else if (mode_q == MODE_IDLE) mode_d = cas_any_i ? MODE_CBR_REF : MODE_ROW_REF;
    else if (mode_q == MODE_ROW_REF && cas_any_i) mode_d = we_ni ? MODE_READ : MODE_EARLY_WR;
    else if (mode_q == MODE_READ && cas_any_i && we_fall)
      mode_d = oe_seen_q ? MODE_RMW : MODE_LATE_WR;
  end

  // remembers an output-enable read phase for RMW detection
  always_comb begin
    oe_seen_d = oe_seen_q;
    if (ras_ni) oe_seen_d = 1'b0;
    else if (mode_d == MODE_READ && cas_any_i && !oe_ni) oe_seen_d = 1'b1;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      mode_q    <= MODE_IDLE;
      oe_seen_q <= 1'b0;
    end else begin
      mode_q    <= mode_d;
      oe_seen_q <= oe_seen_d;
    end
  end

  assign mode_q_o   = mode_q;
  assign mode_nxt_o = mode_d;
  assign wr_ok_o    = !ras_ni && mode_q != MODE_IDLE && mode_q != MODE_CBR_REF;

  a_r1_idle_on_ras_high: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ras_ni |=> mode_q == MODE_IDLE);
  a_r2_cbr_only_from_idle: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mode_q != MODE_IDLE && mode_q != MODE_CBR_REF) |=> mode_q != MODE_CBR_REF);
endmodule

// File: rtl/dram_lane_ctl.sv
module dram_lane_ctl
  import dram_dec_pkg::*;
(
  input  logic     clk_i,
  input  logic     rst_ni,
  input  logic     ras_ni,
  input  logic     cas_ni,
  input  logic     cas_q_i,
  input  logic     we_ni,
  input  logic     we_q_i,
  input  logic     oe_ni,
  input  logic     wr_ok_i,
  input  logic     read_row_i,
  output logic     wr_stb_o,
  output logic     drive_o,
  output wr_kind_e kind_nxt_o
);
  wr_kind_e kind_q, kind_d;
  logic early_ev, late_ev, drv_set, drv_keep;

  assign early_ev = wr_ok_i && !cas_ni && cas_q_i && !we_ni;
  assign late_ev  = wr_ok_i && !cas_ni && !cas_q_i && !we_ni && we_q_i;

  always_comb begin
    kind_d = kind_q;
    if (ras_ni) kind_d = WK_NONE;
    else if (early_ev) kind_d = WK_EARLY;
    else if (late_ev) kind_d = WK_LATE;
  end

  // turn-off waits for the later of row and lane strobe rising
  assign drv_set  = read_row_i && !cas_ni && !oe_ni && we_ni;
  assign drv_keep = drive_o && !oe_ni && we_ni && !(ras_ni && cas_ni);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      kind_q   <= WK_NONE;
      wr_stb_o <= 1'b0;
      drive_o  <= 1'b0;
    end else begin
      kind_q   <= kind_d;
      wr_stb_o <= early_ev || late_ev;
      drive_o  <= drv_set || drv_keep;
    end
  end

  assign kind_nxt_o = kind_d;

  a_r6_oe_high_stops_drive: assert property (@(posedge clk_i) disable iff (!rst_ni)
    oe_ni |=> !drive_o);
  a_r4_pulse_needs_lane_strobe: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cas_ni |=> !wr_stb_o);
  a_r6_write_enable_stops_drive: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !we_ni |=> !drive_o);
endmodule

// File: rtl/dram_cycle_decoder.sv
module dram_cycle_decoder
  import dram_dec_pkg::*;
#(
  parameter int NUM_LANES = 2
) (
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic                 ras_ni,
  input  logic [NUM_LANES-1:0] cas_ni,
  input  logic                 we_ni,
  input  logic                 oe_ni,
  output logic [2:0]           mode_o,
  output logic [NUM_LANES-1:0] wr_stb_o,
  output logic [NUM_LANES-1:0] drive_o,
  output logic                 lane_err_o
);
  logic [NUM_LANES-1:0] cas_q, has_early, has_late;
  logic                 we_q, wr_ok, read_row, err_d;
  cyc_mode_e            mode_q, mode_nxt;
  wr_kind_e             kind_nxt [NUM_LANES];

  dram_strobe_sampler #(.NUM_LANES(NUM_LANES)) u_sampler (
    .clk_i(clk_i), .rst_ni(rst_ni), .cas_ni(cas_ni), .we_ni(we_ni),
    .cas_q_o(cas_q), .we_q_o(we_q)
  );

  dram_mode_fsm u_fsm (
    .clk_i(clk_i), .rst_ni(rst_ni), .ras_ni(ras_ni), .cas_any_i(~&cas_ni),
    .we_ni(we_ni), .we_q_i(we_q), .oe_ni(oe_ni),
    .mode_q_o(mode_q), .mode_nxt_o(mode_nxt), .wr_ok_o(wr_ok)
  );

  assign read_row = mode_nxt == MODE_READ || mode_nxt == MODE_RMW;

  for (genvar g = 0; g < NUM_LANES; g++) begin : g_lane
    dram_lane_ctl u_lane (
      .clk_i(clk_i), .rst_ni(rst_ni), .ras_ni(ras_ni),
      .cas_ni(cas_ni[g]), .cas_q_i(cas_q[g]), .we_ni(we_ni), .we_q_i(we_q),
      .oe_ni(oe_ni), .wr_ok_i(wr_ok), .read_row_i(read_row),
      .wr_stb_o(wr_stb_o[g]), .drive_o(drive_o[g]), .kind_nxt_o(kind_nxt[g])
    );
    assign has_early[g] = kind_nxt[g] == WK_EARLY;
    assign has_late[g]  = kind_nxt[g] == WK_LATE;
  end

  assign err_d = !ras_ni && (lane_err_o || (|has_early && |has_late));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) lane_err_o <= 1'b0;
    else         lane_err_o <= err_d;
  end

  assign mode_o = mode_q;

  a_r10_err_cleared_by_row_high: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ras_ni |=> !lane_err_o);
  a_r2_no_write_in_cbr_row: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mode_q == MODE_CBR_REF && !ras_ni) |=> wr_stb_o == '0);
endmodule

// File: tb/dram_cycle_decoder_tb.sv
module dram_cycle_decoder_tb;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       ras_n = 1'b1, we_n = 1'b1, oe_n = 1'b1;
  logic [1:0] cas_n = 2'b11;
  logic [2:0] mode;
  logic [1:0] wr_stb, drive;
  logic       err;

  int checks = 0, errors = 0;

  // reference model state
  int m_mode = 0, m_seen = 0;
  int m_kind [2] = '{0, 0};
  bit [1:0] m_cprev = 2'b11, m_wr = 2'b00, m_drv = 2'b00;
  bit m_wprev = 1'b1, m_err = 1'b0;

  always #5 clk = ~clk;

  dram_cycle_decoder u_dut (
    .clk_i(clk), .rst_ni(rst_n), .ras_ni(ras_n), .cas_ni(cas_n),
    .we_ni(we_n), .oe_ni(oe_n), .mode_o(mode), .wr_stb_o(wr_stb),
    .drive_o(drive), .lane_err_o(err)
  );

  task automatic check(input string tag, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: got mode/wr/drv/err=%b expected %b", tag, act, exp);
    end
  endtask

  // applies one sample, advances the model, compares after the edge
  task automatic cyc(input bit r, input bit [1:0] c, input bit w, input bit o, input string tag);
    int nm;
    bit ok, any_c, any_e, any_l;
    ras_n = r; cas_n = c; we_n = w; oe_n = o;
    any_c = (c != 2'b11);
    ok = !r && m_mode != 0 && m_mode != 6;
    if (r) nm = 0;
    else if (m_mode == 0) nm = any_c ? 6 : 5;
    else if (m_mode == 5 && any_c) nm = w ? 1 : 2;
    else if (m_mode == 1 && any_c && !w && m_wprev) nm = m_seen ? 4 : 3;
    else nm = m_mode;
    if (r) m_seen = 0;
    else if (nm == 1 && any_c && !o) m_seen = 1;
    any_e = 0; any_l = 0;
    for (int i = 0; i < 2; i++) begin
      bit e, l;
      e = ok && !c[i] && m_cprev[i] && !w;
      l = ok && !c[i] && !m_cprev[i] && !w && m_wprev;
      m_wr[i] = e || l;
      if (r) m_kind[i] = 0; else if (e) m_kind[i] = 1; else if (l) m_kind[i] = 2;
      if (m_kind[i] == 1) any_e = 1;
      if (m_kind[i] == 2) any_l = 1;
      m_drv[i] = (((nm == 1 || nm == 4) && !c[i]) || (m_drv[i] && !(r && c[i]))) && !o && w;
    end
    m_err = !r && (m_err || (any_e && any_l));
    m_cprev = c; m_wprev = w; m_mode = nm;
    @(negedge clk);
    check(tag, {mode, wr_stb, drive, err}, {nm[2:0], m_wr, m_drv, m_err});
  endtask

  initial begin
    #(200000 * 10);
    errors++;
    $display("FAIL watchdog: got running expected finished");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (2) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    check("R1 reset", {mode, wr_stb, drive, err}, 8'h00);
    cyc(1, 2'b11, 1, 1, "R1");
    // word read with output enable, EDO hold, turn-off
    cyc(0, 2'b11, 1, 1, "R3");
    cyc(0, 2'b11, 1, 1, "R3");
    cyc(0, 2'b00, 1, 1, "R5");
    cyc(0, 2'b00, 1, 0, "R5");
    cyc(0, 2'b11, 1, 0, "R6");
    cyc(0, 2'b10, 1, 0, "R9");
    cyc(1, 2'b11, 1, 0, "R6");
    cyc(1, 2'b11, 1, 1, "R1");
    // lower byte read, output enable high first
    cyc(0, 2'b11, 1, 1, "R3");
    cyc(0, 2'b10, 1, 1, "R5");
    cyc(0, 2'b10, 1, 0, "R5");
    cyc(0, 2'b10, 1, 1, "R6");
    cyc(1, 2'b11, 1, 1, "R1");
    // early write word, then page early write upper
    cyc(0, 2'b11, 0, 1, "R3");
    cyc(0, 2'b00, 0, 1, "R4");
    cyc(0, 2'b00, 0, 0, "R4");
    cyc(0, 2'b11, 0, 1, "R9");
    cyc(0, 2'b01, 0, 1, "R9");
    cyc(1, 2'b11, 1, 1, "R1");
    // delayed write
    cyc(0, 2'b11, 1, 1, "R3");
    cyc(0, 2'b00, 1, 1, "R5");
    cyc(0, 2'b00, 0, 1, "R7");
    cyc(0, 2'b00, 0, 1, "R7");
    cyc(1, 2'b11, 1, 1, "R1");
    // read-modify-write on upper lane
    cyc(0, 2'b11, 1, 1, "R3");
    cyc(0, 2'b01, 1, 0, "R8");
    cyc(0, 2'b01, 1, 1, "R8");
    cyc(0, 2'b01, 0, 1, "R8");
    cyc(0, 2'b11, 1, 1, "R8");
    cyc(1, 2'b11, 1, 1, "R1");
    // strobe-first refresh, no writes
    cyc(1, 2'b10, 1, 1, "R2");
    cyc(0, 2'b10, 0, 1, "R2");
    cyc(0, 2'b00, 0, 1, "R2");
    cyc(1, 2'b11, 1, 1, "R1");
    // hidden refresh: read held through row strobe high and new row
    cyc(0, 2'b11, 1, 1, "R3");
    cyc(0, 2'b00, 1, 0, "R5");
    cyc(1, 2'b00, 1, 0, "R6");
    cyc(0, 2'b00, 1, 0, "R2");
    cyc(1, 2'b11, 1, 0, "R6");
    cyc(1, 2'b11, 1, 1, "R1");
    // mixed lanes spread over cycles: early lower, delayed upper
    cyc(0, 2'b11, 0, 1, "R3");
    cyc(0, 2'b10, 0, 1, "R4");
    cyc(0, 2'b11, 1, 1, "R10");
    cyc(0, 2'b01, 1, 1, "R10");
    cyc(0, 2'b01, 0, 1, "R10");
    cyc(0, 2'b01, 0, 1, "R10");
    cyc(1, 2'b11, 1, 1, "R10");
    // mixed lanes in one sample: read row, lower held, upper falls with WE fall
    cyc(0, 2'b11, 1, 1, "R3");
    cyc(0, 2'b10, 1, 1, "R5");
    cyc(0, 2'b00, 0, 1, "R10");
    cyc(1, 2'b11, 1, 1, "R10");
    cyc(1, 2'b11, 1, 1, "R1");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule